// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter Chain

This block keeps the current time and date as a cascade of packed-BCD counters. The counters are seconds, minutes, hours in 24-hour form, day of week, day of month, month, two-digit year and a century above the year. A one-cycle enable pulse, nominally once per second, advances the seconds counter. Each counter that wraps passes a carry to the counter above it. The chain runs synchronously to a single system clock.

A halt input gates the tick so the whole chain freezes on its current values. Counting resumes from those values once the halt is released. A parallel load port replaces every counter in one clock cycle, so a host-side interface can move a shadow copy of the time in atomically. The day of week is a free-running 1 to 7 cycle that steps at midnight, independently of the date. Month lengths and the leap-year rule for February are derived from the full four-digit year.

Top module: `bcd_calendar_chain`

## Requirements
- R1: While rst_n is low, and after it rises, the outputs read sec 0x00, min 0x00, hour 0x00, dow 0x01, date 0x01, month 0x01, year 0x00, cent 0x00.
- R2: Every output is packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. An accepted tick adds one second. Seconds and minutes wrap 59 to 00, and each wrap adds one to the next field. Hours wrap 23 to 00.
- R3: An accepted tick is tick_1hz high with halt and load_en low on a rising clock edge. Its effect shows on the outputs right after that edge. With no accepted tick and no load, no output changes.
- R4: While halt is high, no counter changes on a tick. After halt falls, counting continues from the held values.
- R5: At each midnight rollover (23:59:59 to 00:00:00), dow steps by one and wraps from 07 to 01, whatever the date.
- R6: Year wraps 99 to 00 and then adds one to the century. Century wraps 39 to 00.
- R7: Date wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in months 01, 03, 05, 07, 08, 10 and 12, adding one to the month. Month 12 wraps to 01 and adds one to the year.
- R8: February ends on day 29 when century*100+year is divisible by 4 and is either not divisible by 100 or is divisible by 400. Otherwise it ends on day 28.
- R9: With load_en high on an edge, all eight counters take the load values on that edge. This holds even while halt is high. A tick in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle advance enable |
| halt | input | 1 | Freezes counting while high |
| load_en | input | 1 | Loads all counters from the ld_* inputs |
| ld_sec | input | 8 | Seconds load value, BCD |
| ld_min | input | 8 | Minutes load value, BCD |
| ld_hour | input | 8 | Hours load value, BCD |
| ld_dow | input | 8 | Day-of-week load value, BCD |
| ld_date | input | 8 | Day-of-month load value, BCD |
| ld_month | input | 8 | Month load value, BCD |
| ld_year | input | 8 | Year load value, BCD |
| ld_cent | input | 8 | Century load value, BCD |
| sec | output | 8 | Seconds 00-59 |
| min | output | 8 | Minutes 00-59 |
| hour | output | 8 | Hours 00-23 |
| dow | output | 8 | Day of week 01-07 |
| date | output | 8 | Day of month 01-31 |
| month | output | 8 | Month 01-12 |
| year | output | 8 | Year 00-99 |
| cent | output | 8 | Century 00-39 |

## Verification
A wrong counter value shows on its output port in the cycle right after the edge that caused it. A wrong carry or wrong month length does not show until the lower fields reach their wrap point. The bench therefore loads values just short of each wrap: end of minute, end of day, end of each month length, end of February in leap and non-leap years, end of year and end of century. It then ticks across the boundary. A behavioural model is compared against every output on every clock, so a stray change in a field that should be idle is caught within one cycle.

// File: rtl/cal_pkg.sv
// Package: shared widths, field indices and BCD helpers for the calendar chain.
// Assumes packed BCD bytes; values are not range-checked anywhere.
package cal_pkg;
    localparam int BCD_W    = 8;
    localparam int NFIELDS  = 8;

    // Field index order: lowest-order counter first.
    localparam int F_SEC   = 0;
    localparam int F_MIN   = 1;
    localparam int F_HOUR  = 2;
    localparam int F_DOW   = 3;
    localparam int F_DATE  = 4;
    localparam int F_MONTH = 5;
    localparam int F_YEAR  = 6;
    localparam int F_CENT  = 7;

    typedef logic [BCD_W-1:0] bcd_t;

    // Wrap-to value for each field (index 7 written first).
    localparam logic [NFIELDS-1:0][BCD_W-1:0] FIELD_FIRST =
        {8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    // Fixed last value for each field; the date entry is replaced at run time.
    localparam logic [NFIELDS-1:0][BCD_W-1:0] FIELD_LAST =
        {8'h39, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59};

    // Index of the field whose carry advances field g (sec has none).
    function automatic int carry_src(input int g);
        case (g)
            F_DOW, F_DATE: carry_src = F_HOUR;
            F_MONTH:       carry_src = F_DATE;
            default:       carry_src = g - 1;
        endcase
    endfunction

    // Add one to a two-digit packed BCD value.
    function automatic bcd_t bcd_inc(input bcd_t v);
        if (v[3:0] == 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
        else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
    endfunction

    // True when a two-digit BCD value is a multiple of four.
    function automatic logic bcd_div4(input bcd_t v);
        if (v[4] == 1'b0) bcd_div4 = (v[3:0] == 4'd0) || (v[3:0] == 4'd4) || (v[3:0] == 4'd8);
        else              bcd_div4 = (v[3:0] == 4'd2) || (v[3:0] == 4'd6);
    endfunction
endpackage

// File: rtl/cal_bcd_pair.sv
// Module: one two-digit BCD counter stage of the chain.
// Counts up on adv, wraps from last_val to FIRST and flags the wrap on carry.
// A load takes priority over counting. Assumes valid BCD contents.
module cal_bcd_pair
    import cal_pkg::*;
#(
    parameter bcd_t FIRST = 8'h00
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  bcd_t last_val,
    input  logic ld,
    input  bcd_t ld_val,
    output bcd_t val,
    output logic carry
);
    // Wrap indication passed to the next stage.
    always_comb carry = adv && (val == last_val);

    // Counter register: reset, load, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)       val <= FIRST;
        else if (ld)      val <= ld_val;
        else if (adv)     val <= carry ? FIRST : bcd_inc(val);
    end
endmodule

// File: rtl/cal_month_len.sv
// Module: last valid day of the current month, in BCD.
// FULL_LEAP=1 applies the full four-digit leap rule using the century;
// FULL_LEAP=0 uses divisibility of the two-digit year by four only.
module cal_month_len
    import cal_pkg::*;
#(
    parameter bit FULL_LEAP = 1'b1
) (
    input  bcd_t month,
    input  bcd_t year,
    input  bcd_t cent,
    output bcd_t last_day
);
    logic leap;

    // Leap-year decision, variant chosen by parameter.
    generate
        if (FULL_LEAP) begin : g_full
            always_comb leap = (year == 8'h00) ? bcd_div4(cent) : bcd_div4(year);
        end else begin : g_simple
            logic unused_cent;
            always_comb unused_cent = ^cent;
            always_comb leap = bcd_div4(year);
        end
    endgenerate

    // Month-length lookup.
    always_comb begin
        case (month)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end
endmodule

// File: rtl/bcd_calendar_chain.sv
// Module: top of the BCD time/date cascade.
// A gated tick advances seconds; each stage's wrap advances the next.
// Day of week and date both step on the hour wrap; a load replaces all
// fields in one cycle and suppresses the tick of that cycle.
module bcd_calendar_chain
    import cal_pkg::*;
#(
    parameter bit FULL_LEAP = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1hz,
    input  logic       halt,
    input  logic       load_en,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    input  logic [7:0] ld_dow,
    input  logic [7:0] ld_date,
    input  logic [7:0] ld_month,
    input  logic [7:0] ld_year,
    input  logic [7:0] ld_cent,
    output logic [7:0] sec,
    output logic [7:0] min,
    output logic [7:0] hour,
    output logic [7:0] dow,
    output logic [7:0] date,
    output logic [7:0] month,
    output logic [7:0] year,
    output logic [7:0] cent
);
    bcd_t               ld_arr   [NFIELDS];
    bcd_t               val_arr  [NFIELDS];
    bcd_t               last_arr [NFIELDS];
    logic [NFIELDS-1:0] adv_v;
    logic [NFIELDS-1:0] carry_v;
    logic               step;
    bcd_t               date_last;

    // Accepted tick: load and halt both block it.
    always_comb step = tick_1hz && !halt && !load_en;

    // Gather load inputs into field order.
    always_comb begin
        ld_arr[F_SEC]   = ld_sec;
        ld_arr[F_MIN]   = ld_min;
        ld_arr[F_HOUR]  = ld_hour;
        ld_arr[F_DOW]   = ld_dow;
        ld_arr[F_DATE]  = ld_date;
        ld_arr[F_MONTH] = ld_month;
        ld_arr[F_YEAR]  = ld_year;
        ld_arr[F_CENT]  = ld_cent;
    end

    cal_month_len #(.FULL_LEAP(FULL_LEAP)) u_mlen (
        .month    (val_arr[F_MONTH]),
        .year     (val_arr[F_YEAR]),
        .cent     (val_arr[F_CENT]),
        .last_day (date_last)
    );

    generate
        for (genvar g = 0; g < NFIELDS; g++) begin : g_stage
            // Advance source for this stage.
            if (g == F_SEC) begin : g_src_tick
                always_comb adv_v[g] = step;
            end else begin : g_src_carry
                always_comb adv_v[g] = carry_v[carry_src(g)];
            end
            // Wrap point: fixed, or month length for the date.
            if (g == F_DATE) begin : g_last_dyn
                always_comb last_arr[g] = date_last;
            end else begin : g_last_fix
                always_comb last_arr[g] = FIELD_LAST[g];
            end
            cal_bcd_pair #(.FIRST(FIELD_FIRST[g])) u_ctr (
                .clk      (clk),
                .rst_n    (rst_n),
                .adv      (adv_v[g]),
                .last_val (last_arr[g]),
                .ld       (load_en),
                .ld_val   (ld_arr[g]),
                .val      (val_arr[g]),
                .carry    (carry_v[g])
            );
        end
    endgenerate

    // Present the counters on the output ports.
    always_comb begin
        sec   = val_arr[F_SEC];
        min   = val_arr[F_MIN];
        hour  = val_arr[F_HOUR];
        dow   = val_arr[F_DOW];
        date  = val_arr[F_DATE];
        month = val_arr[F_MONTH];
        year  = val_arr[F_YEAR];
        cent  = val_arr[F_CENT];
    end
endmodule

// File: rtl/cal_chain_checker.sv
// Module: port-level assertions for bcd_calendar_chain, bound to it below.
module cal_chain_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_1hz,
    input logic       halt,
    input logic       load_en,
    input logic [7:0] ld_sec,
    input logic [7:0] ld_min,
    input logic [7:0] ld_hour,
    input logic [7:0] ld_dow,
    input logic [7:0] ld_date,
    input logic [7:0] ld_month,
    input logic [7:0] ld_year,
    input logic [7:0] ld_cent,
    input logic [7:0] sec,
    input logic [7:0] min,
    input logic [7:0] hour,
    input logic [7:0] dow,
    input logic [7:0] date,
    input logic [7:0] month,
    input logic [7:0] year,
    input logic [7:0] cent
);
    logic acc;
    logic eod;
    always_comb acc = tick_1hz && !halt && !load_en;
    always_comb eod = (hour == 8'h23) && (min == 8'h59) && (sec == 8'h59);

    assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1hz && !load_en) |=> ($stable(sec) && $stable(min) && $stable(hour) && $stable(dow)
                                     && $stable(date) && $stable(month) && $stable(year) && $stable(cent)));

    assert_halt_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !load_en) |=> ($stable(sec) && $stable(min) && $stable(hour) && $stable(dow)
                                && $stable(date) && $stable(month) && $stable(year) && $stable(cent)));

    assert_load_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (sec == $past(ld_sec) && min == $past(ld_min) && hour == $past(ld_hour)
                     && dow == $past(ld_dow) && date == $past(ld_date) && month == $past(ld_month)
                     && year == $past(ld_year) && cent == $past(ld_cent)));

    assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && sec == 8'h59) |=> (sec == 8'h00 && min != $past(min)));

    assert_dow_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && eod && dow == 8'h07) |=> (dow == 8'h01 && hour == 8'h00));

    assert_century_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && eod && date == 8'h31 && month == 8'h12 && year == 8'h99 && cent != 8'h39)
        |=> (year == 8'h00 && month == 8'h01 && cent != $past(cent)));
endmodule

bind bcd_calendar_chain cal_chain_checker u_chk (.*);

// File: tb/sim_bcd_calendar_chain.sv
// Bench: behavioural calendar model compared with the block on every clock,
// plus directed boundary checks.
module sim_bcd_calendar_chain;
    localparam time PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1hz = 1'b0, halt = 1'b0, load_en = 1'b0;
    logic [7:0] ld_sec = '0, ld_min = '0, ld_hour = '0, ld_dow = '0;
    logic [7:0] ld_date = '0, ld_month = '0, ld_year = '0, ld_cent = '0;
    logic [7:0] sec, min, hour, dow, date, month, year, cent;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state as integers.
    int m_s, m_mi, m_h, m_dw, m_d, m_mo, m_y, m_c;

    always #(PERIOD/2) clk = ~clk;

    bcd_calendar_chain u0 (.*);

    function automatic logic [7:0] to_bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int month_days(input int mo, input int fy);
        bit lp;
        lp = (fy % 4 == 0) && ((fy % 100 != 0) || (fy % 400 == 0));
        if (mo == 2) return lp ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s = 0; m_mi = 0; m_h = 0; m_dw = 1; m_d = 1; m_mo = 1; m_y = 0; m_c = 0;
        end else if (load_en) begin
            m_s = from_bcd(ld_sec); m_mi = from_bcd(ld_min); m_h = from_bcd(ld_hour);
            m_dw = from_bcd(ld_dow); m_d = from_bcd(ld_date); m_mo = from_bcd(ld_month);
            m_y = from_bcd(ld_year); m_c = from_bcd(ld_cent);
        end else if (tick_1hz && !halt) begin
            m_s++;
            if (m_s == 60) begin
                m_s = 0; m_mi++;
                if (m_mi == 60) begin
                    m_mi = 0; m_h++;
                    if (m_h == 24) begin
                        m_h = 0;
                        m_dw = (m_dw == 7) ? 1 : m_dw + 1;
                        if (m_d == month_days(m_mo, m_c * 100 + m_y)) begin
                            m_d = 1; m_mo++;
                            if (m_mo == 13) begin
                                m_mo = 1; m_y++;
                                if (m_y == 100) begin
                                    m_y = 0;
                                    m_c = (m_c == 39) ? 0 : m_c + 1;
                                end
                            end
                        end else m_d++;
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input string fld, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, fld, got, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model (R2 counting path).
    always @(negedge clk) begin
        if (!done) begin
            chk("R2", "sec",   sec,   to_bcd(m_s));
            chk("R2", "min",   min,   to_bcd(m_mi));
            chk("R2", "hour",  hour,  to_bcd(m_h));
            chk("R5", "dow",   dow,   to_bcd(m_dw));
            chk("R7", "date",  date,  to_bcd(m_d));
            chk("R7", "month", month, to_bcd(m_mo));
            chk("R6", "year",  year,  to_bcd(m_y));
            chk("R6", "cent",  cent,  to_bcd(m_c));
        end
    end

    task automatic load_all(input int s, input int mi, input int h, input int dw,
                            input int d, input int mo, input int y, input int c);
        @(negedge clk);
        ld_sec = to_bcd(s); ld_min = to_bcd(mi); ld_hour = to_bcd(h); ld_dow = to_bcd(dw);
        ld_date = to_bcd(d); ld_month = to_bcd(mo); ld_year = to_bcd(y); ld_cent = to_bcd(c);
        load_en = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_1hz = 1'b1;
        for (int i = 1; i < n; i++) @(negedge clk);
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "sec", sec, 8'h00); chk("R1", "dow", dow, 8'h01);
        chk("R1", "date", date, 8'h01); chk("R1", "month", month, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "cent", cent, 8'h00);

        // R2/R3: long run across minutes and hours
        ticks(4000);
        chk("R2", "min", min, 8'h06); chk("R2", "hour", hour, 8'h01);
        chk("R3", "sec", sec, 8'h40);
        repeat (5) @(negedge clk);
        chk("R3", "sec idle", sec, 8'h40);

        // R4: halt freezes, then resumes
        halt = 1'b1; ticks(7);
        chk("R4", "sec halted", sec, 8'h40);
        halt = 1'b0; ticks(3);
        chk("R4", "sec resumed", sec, 8'h43);

        // R5/R6/R7: end of year 1999, dow 7
        load_all(59, 59, 23, 7, 31, 12, 99, 19);
        ticks(1);
        chk("R5", "dow", dow, 8'h01); chk("R6", "cent", cent, 8'h20);
        chk("R6", "year", year, 8'h00); chk("R7", "month", month, 8'h01);
        chk("R2", "hour", hour, 8'h00);

        // R6: century wrap 39 -> 00
        load_all(59, 59, 23, 3, 31, 12, 99, 39);
        ticks(1);
        chk("R6", "cent wrap", cent, 8'h00);
        chk("R5", "dow", dow, 8'h04); chk("R7", "date", date, 8'h01);

        // R7: 30-day month and 31-day month
        load_all(59, 59, 23, 2, 30, 4, 21, 20);
        ticks(1);
        chk("R7", "apr->may", month, 8'h05); chk("R7", "date", date, 8'h01);
        load_all(59, 59, 23, 2, 30, 5, 21, 20);
        ticks(1);
        chk("R7", "may 31", date, 8'h31);

        // R8: February variants
        load_all(59, 59, 23, 1, 28, 2, 0, 20);
        ticks(1);
        chk("R8", "2000 feb29", date, 8'h29);
        load_all(59, 59, 23, 1, 28, 2, 0, 19);
        ticks(1);
        chk("R8", "1900 mar", month, 8'h03);
        load_all(59, 59, 23, 1, 28, 2, 24, 20);
        ticks(1);
        chk("R8", "2024 feb29", date, 8'h29);
        ticks(86400);
        chk("R8", "2024 mar01", month, 8'h03);
        load_all(59, 59, 23, 1, 28, 2, 23, 20);
        ticks(1);
        chk("R8", "2023 mar", date, 8'h01);

        // R9: load with tick in same cycle, and load under halt
        @(negedge clk);
        ld_sec = 8'h10; ld_min = 8'h20; ld_hour = 8'h05; ld_dow = 8'h06;
        ld_date = 8'h15; ld_month = 8'h08; ld_year = 8'h42; ld_cent = 8'h21;
        load_en = 1'b1; tick_1hz = 1'b1; halt = 1'b1;
        @(negedge clk);
        load_en = 1'b0; tick_1hz = 1'b0; halt = 1'b0;
        chk("R9", "sec", sec, 8'h10); chk("R9", "year", year, 8'h42);
        chk("R9", "cent", cent, 8'h21);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule